// File: doc/BRIEF.md
# Fixed-Point Logistic Regression SGD Trainer

This block trains a binary logistic-regression model on chip, one labelled sample at a time, by stochastic gradient descent in signed fixed point. A start pulse either zeroes the weight store or, with `preload` high, keeps the weights already held. The block then takes samples from a valid/ready stream, `NFEAT` feature words per sample. While the words arrive it copies each one into a local buffer and adds its product with the matching weight into a wide accumulator. The sum is rounded to the weight format and passed through a piecewise-linear sigmoid. The block forms the error of that prediction against the 0/1 label, then makes a second pass over the buffered features in which it rewrites every weight. The learning rate is a power-of-two shift. After `NSAMP` samples per epoch and `NEPOCH` epochs it pulses `done`, and the weights stay readable through a combinational address/data port.

The controller has six states. IDLE waits for start. Start without preload goes to CLEAR, and start with preload goes to LOAD. CLEAR writes zero to one weight per cycle and moves to LOAD after the last address. LOAD accepts feature beats and moves to ACT once the last beat of a sample has been taken. ACT registers the prediction error and always moves to UPDATE one cycle later. UPDATE rewrites one weight per cycle. After the last weight it returns to LOAD for the next sample, or goes to FIN when that sample was the last of the last epoch. FIN raises `done` for one cycle and returns to IDLE.

Top module: `lr_sgd_trainer`

## Requirements
- R1: After reset, `done`, `busy` and `in_ready` are 0 and every weight reads back as 0.
- R2: A start with `preload` low clears all weights to zero. `in_ready` stays low for exactly `NFEAT` cycles after start before the first feature is accepted.
- R3: A start with `preload` high keeps the current weights. `in_ready` is high in the first cycle after start, and training continues from the held weights.
- R4: The activation input z is the exact sum of weight×feature products, rounded half-up to the weight format (`FRAC` fractional bits) and saturated to the signed `WW`-bit range.
- R5: The prediction is p = clamp(ONE/2 + (z >>> 3), 0, ONE) with ONE = 2^FRAC, so p is 0 for z ≤ −4.0 and 1.0 for z ≥ 4.0.
- R6: The error is p − y·ONE, where y is the `in_label` value taken on the last feature beat of the sample; the label on earlier beats is ignored.
- R7: Each weight i becomes w_i − round_half_up(err·x_i / 2^(FRAC+SHIFT)), saturated to the signed `WW`-bit range.
- R8: After the last feature beat of a sample, `in_ready` is low for exactly `NFEAT`+1 cycles (ACT plus one cycle per weight rewritten) before the next sample can start.
- R9: After `NSAMP`×`NEPOCH` samples, `done` is high for exactly one cycle, in the cycle after the last weight write, and `busy` is low from the next cycle on.
- R10: `rd_data` shows the weight at `rd_addr` in the same cycle, and the weights do not change while the block is idle.
- R11: Weight updates saturate at +2^(WW−1)−1 and −2^(WW−1) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a training run when idle |
| preload | input | 1 | Sampled with start: 1 keeps existing weights |
| in_valid | input | 1 | Feature beat valid |
| in_ready | output | 1 | Trainer can take a feature beat |
| in_data | input | WW | Signed fixed-point feature value |
| in_label | input | 1 | Sample label, taken on the last feature beat |
| done | output | 1 | One-cycle pulse at the end of training |
| busy | output | 1 | High from start until training ends |
| rd_addr | input | clog2(NFEAT) | Weight readout address |
| rd_data | output | WW | Signed weight at rd_addr |

## Verification
A feature beat is taken at the clock edge where `in_valid` and `in_ready` are both high. The bench drives on the falling edge and samples `in_ready` there, so the value it sees is the one the next rising edge will act on. From the falling edge after the last beat it counts `NFEAT`+1 low cycles of `in_ready`, and for the final sample it expects `done` in the falling edge that ends that count and `done` and `busy` low one falling edge later. Weights are read 1 ns after `rd_addr` is set, because readout is combinational. Expected weights come from an integer model of the rounding, sigmoid and saturation rules. A second instance with 14 fractional bits and no rate shift cannot push |z| to 4.0, so its sigmoid never settles and its weights are driven into both saturation limits.

// File: rtl/lr_pkg.sv
package lr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD,
        ST_ACT,
        ST_UPDATE,
        ST_FIN
    } lr_state_e;
endpackage

// File: rtl/lr_regfile.sv
// Register-file store with one write port and NRD combinational read ports.
module lr_regfile #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 16,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr [NRD],
    output logic [WIDTH-1:0] rdata [NRD]
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/lr_sigmoid.sv
// Piecewise-linear sigmoid: 0.5 + z/8, clamped to [0, 1].
module lr_sigmoid #(
    parameter int WW   = 16,
    parameter int FRAC = 10
) (
    input  logic signed [WW-1:0] z,
    output logic signed [WW-1:0] p
);
    localparam logic signed [WW+1:0] HALF = (WW+2)'(1 << (FRAC - 1));
    localparam logic signed [WW+1:0] ONE  = (WW+2)'(1 << FRAC);

    logic signed [WW+1:0] t;

    always_comb begin
        t = HALF + ((WW+2)'(z) >>> 3);
        if (t < 0)        p = '0;
        else if (t > ONE) p = ONE[WW-1:0];
        else              p = t[WW-1:0];
    end
endmodule

// File: rtl/lr_update_alu.sv
// w_new = sat(w - round(err * x / 2^(FRAC+SHIFT)))
module lr_update_alu #(
    parameter int WW    = 16,
    parameter int FRAC  = 10,
    parameter int SHIFT = 6
) (
    input  logic signed [WW-1:0] w,
    input  logic signed [WW-1:0] x,
    input  logic signed [WW:0]   err,
    output logic signed [WW-1:0] w_new
);
    localparam int PW = 2*WW + 3;
    localparam int SH = FRAC + SHIFT;
    localparam logic signed [PW-1:0] RB   = PW'(1) <<< (SH - 1);
    localparam logic signed [PW-1:0] WMAX = PW'((1 << (WW - 1)) - 1);
    localparam logic signed [PW-1:0] WMIN = PW'(-(1 << (WW - 1)));

    logic signed [PW-1:0] prod, step, diff;

    always_comb begin
        prod = PW'(err) * PW'(x);
        step = (prod + RB) >>> SH;
        diff = PW'(w) - step;
        if (diff > WMAX)      w_new = WMAX[WW-1:0];
        else if (diff < WMIN) w_new = WMIN[WW-1:0];
        else                  w_new = diff[WW-1:0];
    end
endmodule

// File: rtl/lr_sgd_trainer.sv
module lr_sgd_trainer #(
    parameter int NFEAT  = 1024,
    parameter int NSAMP  = 5000,
    parameter int NEPOCH = 5,
    parameter int WW     = 16,
    parameter int FRAC   = 10,
    parameter int SHIFT  = 6,
    localparam int AW    = $clog2(NFEAT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          preload,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [WW-1:0] in_data,
    input  logic          in_label,
    output logic          done,
    output logic          busy,
    input  logic [AW-1:0] rd_addr,
    output logic [WW-1:0] rd_data
);
    import lr_pkg::*;

    localparam int SCW  = $clog2(NSAMP + 1);
    localparam int ECW  = $clog2(NEPOCH + 1);
    localparam int ACCW = 2*WW + AW + 2;
    localparam logic signed [ACCW-1:0] ZRND = ACCW'(1 << (FRAC - 1));
    localparam logic signed [ACCW-1:0] ZMAX = ACCW'((1 << (WW - 1)) - 1);
    localparam logic signed [ACCW-1:0] ZMIN = ACCW'(-(1 << (WW - 1)));
    localparam logic signed [WW:0]     ONE_E  = (WW+1)'(1 << FRAC);
    localparam logic signed [WW:0]     ZERO_E = '0;

    lr_state_e state, nxt;
    logic [AW-1:0]           idx;
    logic [SCW-1:0]          samp;
    logic [ECW-1:0]          epoch;
    logic signed [ACCW-1:0]  acc, z_full;
    logic signed [WW:0]      err_q;
    logic                    lab_q;
    logic                    fire, idx_last, samp_last, epoch_last;
    logic signed [WW-1:0]    w_cur, x_cur, x_in, w_new, z_sat, p_sig;
    logic                    w_we;
    logic [WW-1:0]           w_wdata;
    logic [AW-1:0]           w_raddr [2];
    logic [WW-1:0]           w_rdata [2];
    logic [AW-1:0]           f_raddr [1];
    logic [WW-1:0]           f_rdata [1];

    // Weight store: port 0 for the datapath, port 1 for readout.
    lr_regfile #(.DEPTH(NFEAT), .WIDTH(WW), .NRD(2)) u_wmem (
        .clk(clk), .rst_n(rst_n), .we(w_we), .waddr(idx), .wdata(w_wdata),
        .raddr(w_raddr), .rdata(w_rdata)
    );

    // Feature buffer, filled during LOAD and reread during UPDATE.
    lr_regfile #(.DEPTH(NFEAT), .WIDTH(WW), .NRD(1)) u_fbuf (
        .clk(clk), .rst_n(rst_n), .we(fire), .waddr(idx), .wdata(in_data),
        .raddr(f_raddr), .rdata(f_rdata)
    );

    lr_sigmoid #(.WW(WW), .FRAC(FRAC)) u_sig (.z(z_sat), .p(p_sig));

    lr_update_alu #(.WW(WW), .FRAC(FRAC), .SHIFT(SHIFT)) u_alu (
        .w(w_cur), .x(x_cur), .err(err_q), .w_new(w_new)
    );

    always_comb begin
        w_raddr[0] = idx;
        w_raddr[1] = rd_addr;
        f_raddr[0] = idx;
        w_cur      = $signed(w_rdata[0]);
        x_cur      = $signed(f_rdata[0]);
        x_in       = $signed(in_data);
        rd_data    = w_rdata[1];
        idx_last   = (idx == AW'(NFEAT - 1));
        samp_last  = (samp == SCW'(NSAMP - 1));
        epoch_last = (epoch == ECW'(NEPOCH - 1));
        z_full     = (acc + ZRND) >>> FRAC;
        if (z_full > ZMAX)      z_sat = ZMAX[WW-1:0];
        else if (z_full < ZMIN) z_sat = ZMIN[WW-1:0];
        else                    z_sat = z_full[WW-1:0];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = preload ? ST_LOAD : ST_CLEAR;
            ST_CLEAR:  if (idx_last) nxt = ST_LOAD;
            ST_LOAD:   if (fire && idx_last) nxt = ST_ACT;
            ST_ACT:    nxt = ST_UPDATE;
            ST_UPDATE: if (idx_last) nxt = (samp_last && epoch_last) ? ST_FIN : ST_LOAD;
            ST_FIN:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs and store controls
    always_comb begin
        in_ready = (state == ST_LOAD);
        fire     = in_ready && in_valid;
        done     = (state == ST_FIN);
        busy     = (state != ST_IDLE);
        w_we     = (state == ST_CLEAR) || (state == ST_UPDATE);
        w_wdata  = (state == ST_CLEAR) ? '0 : w_new;
    end

    // Datapath and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            samp  <= '0;
            epoch <= '0;
            acc   <= '0;
            err_q <= '0;
            lab_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    idx   <= '0;
                    samp  <= '0;
                    epoch <= '0;
                    acc   <= '0;
                end
                ST_CLEAR: idx <= idx_last ? '0 : idx + 1'b1;
                ST_LOAD: if (fire) begin
                    acc <= acc + ACCW'(w_cur) * ACCW'(x_in);
                    idx <= idx_last ? '0 : idx + 1'b1;
                    if (idx_last) lab_q <= in_label;
                end
                ST_ACT: err_q <= (WW+1)'(p_sig) - (lab_q ? ONE_E : ZERO_E);
                ST_UPDATE: begin
                    if (idx_last) begin
                        idx <= '0;
                        acc <= '0;
                        if (samp_last) begin
                            samp  <= '0;
                            epoch <= epoch + 1'b1;
                        end else begin
                            samp <= samp + 1'b1;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_FIN: ;
                default: ;
            endcase
        end
    end

    // Sigmoid output stays in [0, ONE] when the error is formed.
    assert_sig_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACT) |-> (p_sig >= 0 && (WW+1)'(p_sig) <= ONE_E));

    // Last beat of a sample closes the stream for the update pass.
    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && idx_last) |=> !in_ready);

    // Completion is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Idle weights hold still under a fixed read address.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE && $stable(rd_addr)) |-> $stable(rd_data));

    // Negative error with a non-negative feature can only raise a weight (no wrap).
    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE && err_q < 0 && x_cur >= 0) |-> (w_new >= w_cur));
endmodule

// File: tb/tb_lr_sgd_trainer.sv
module tb_lr_sgd_trainer;
    localparam int NF = 4, NS = 3, NE = 2, WW = 16, AW = 2;
    localparam int FR_M = 10, SH_M = 2, FR_S = 14, SH_S = 0;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, start_m, start_s, preload, in_valid, in_label;
    logic [WW-1:0] in_data;
    logic [AW-1:0] rd_addr;
    logic rdy_m, done_m, busy_m, rdy_s, done_s, busy_s;
    logic [WW-1:0] rd_m, rd_s;
    int errors = 0, checks = 0;
    bit finished = 1'b0;
    longint wm [NF];
    longint ws [NF];

    lr_sgd_trainer #(.NFEAT(NF), .NSAMP(NS), .NEPOCH(NE), .WW(WW), .FRAC(FR_M), .SHIFT(SH_M)) dut (
        .clk(clk), .rst_n(rst_n), .start(start_m), .preload(preload), .in_valid(in_valid),
        .in_ready(rdy_m), .in_data(in_data), .in_label(in_label), .done(done_m), .busy(busy_m),
        .rd_addr(rd_addr), .rd_data(rd_m));

    lr_sgd_trainer #(.NFEAT(NF), .NSAMP(NS), .NEPOCH(NE), .WW(WW), .FRAC(FR_S), .SHIFT(SH_S)) dut_sat (
        .clk(clk), .rst_n(rst_n), .start(start_s), .preload(preload), .in_valid(in_valid),
        .in_ready(rdy_s), .in_data(in_data), .in_label(in_label), .done(done_s), .busy(busy_s),
        .rd_addr(rd_addr), .rd_data(rd_s));

    function automatic longint feat(int run, int s, int i);
        case (run)
            0: return longint'(((s*37 + i*91 + 13) % 400) - 200);
            1: return longint'(((s*53 + i*29 + 7) % 3000) - 1500);
            2: return longint'(((s*11 + i*71) % 2000) - 1000);
            default: return 64'sd32767;
        endcase
    endfunction

    function automatic bit lab(int run, int s);
        case (run)
            0: return (s % 2) == 1;
            1: return s == 1;
            2: return s != 0;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic longint sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Integer model of one full training run (R4, R5, R6, R7, R11).
    task automatic model(input int run, input bit sel);
        longint w [NF];
        longint acc, z, p, err, d, one;
        int fr, sh;
        fr  = sel ? FR_S : FR_M;
        sh  = sel ? SH_S : SH_M;
        one = longint'(1) <<< fr;
        for (int i = 0; i < NF; i++) w[i] = sel ? ws[i] : wm[i];
        for (int e = 0; e < NE; e++) begin
            for (int s = 0; s < NS; s++) begin
                acc = 0;
                for (int i = 0; i < NF; i++) acc += w[i] * feat(run, s, i);
                z = sat16((acc + (longint'(1) <<< (fr - 1))) >>> fr);
                p = one / 2 + (z >>> 3);
                if (p < 0) p = 0;
                if (p > one) p = one;
                err = p - (lab(run, s) ? one : 0);
                for (int i = 0; i < NF; i++) begin
                    d = (err * feat(run, s, i) + (longint'(1) <<< (fr + sh - 1))) >>> (fr + sh);
                    w[i] = sat16(w[i] - d);
                end
            end
        end
        for (int i = 0; i < NF; i++) begin
            if (sel) ws[i] = w[i];
            else     wm[i] = w[i];
        end
    endtask

    task automatic push(input bit sel, input longint x, input bit lb);
        bit hit;
        in_valid = 1'b1;
        in_data  = WW'(x);
        in_label = lb;
        forever begin
            hit = sel ? rdy_s : rdy_m;
            @(negedge clk);
            if (hit) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic read_w(input bit sel, input int i, output longint v);
        rd_addr = AW'(i);
        #1;
        v = sel ? longint'($signed(rd_s)) : longint'($signed(rd_m));
    endtask

    task automatic run_train(input int run, input bit sel, input bit pre);
        int n;
        preload = pre;
        if (sel) start_s = 1'b1; else start_m = 1'b1;
        @(negedge clk);
        start_m = 1'b0;
        start_s = 1'b0;
        preload = 1'b0;
        check("R9 busy after start", sel ? busy_s : busy_m, 1);
        n = 0;
        while (!(sel ? rdy_s : rdy_m)) begin n++; @(negedge clk); end
        if (pre) check("R3 preload skips clear", n, 0);
        else     check("R2 clear cycles", n, NF);
        for (int e = 0; e < NE; e++) begin
            for (int s = 0; s < NS; s++) begin
                for (int i = 0; i < NF; i++) begin
                    if (((i + s + run) % 3) == 1) @(negedge clk);
                    // R6: only the last beat carries the true label.
                    push(sel, feat(run, s, i), (i == NF - 1) ? lab(run, s) : !lab(run, s));
                end
                n = 0;
                while (!(sel ? rdy_s : rdy_m) && !(sel ? done_s : done_m)) begin
                    n++;
                    @(negedge clk);
                end
                check("R8 ready gap after sample", n, NF + 1);
                if (e == NE - 1 && s == NS - 1) begin
                    check("R9 done raised", sel ? done_s : done_m, 1);
                    @(negedge clk);
                    check("R9 done one cycle", sel ? done_s : done_m, 0);
                    check("R9 busy cleared", sel ? busy_s : busy_m, 0);
                end else begin
                    check("R9 no early done", sel ? done_s : done_m, 0);
                end
            end
        end
        if (!pre) begin
            for (int i = 0; i < NF; i++) begin
                if (sel) ws[i] = 0; else wm[i] = 0;
            end
        end
        model(run, sel);
        for (int i = 0; i < NF; i++) begin
            longint v;
            read_w(sel, i, v);
            check("R4 R5 R6 R7 trained weight", v, sel ? ws[i] : wm[i]);
        end
    endtask

    initial begin
        longint v, v2;
        rst_n = 1'b0; start_m = 1'b0; start_s = 1'b0; preload = 1'b0;
        in_valid = 1'b0; in_label = 1'b0; in_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 done", done_m, 0);
        check("R1 busy", busy_m, 0);
        check("R1 in_ready", rdy_m, 0);
        for (int i = 0; i < NF; i++) begin
            read_w(1'b0, i, v);
            check("R1 weight zero", v, 0);
        end

        run_train(0, 1'b0, 1'b0);
        run_train(1, 1'b0, 1'b1);   // R3: continues from held weights
        run_train(2, 1'b0, 1'b0);   // R2: restarts from zero

        // R10: readout is immediate and idle weights hold
        read_w(1'b0, 1, v);
        repeat (7) @(negedge clk);
        read_w(1'b0, 1, v2);
        check("R10 idle hold", v2, v);
        read_w(1'b0, 3, v);
        check("R10 same-cycle readout", v, wm[3]);

        // R11: saturation at both limits
        run_train(3, 1'b1, 1'b0);
        for (int i = 0; i < NF; i++) begin
            read_w(1'b1, i, v);
            check("R11 positive limit", v, 32767);
        end
        run_train(4, 1'b1, 1'b0);
        for (int i = 0; i < NF; i++) begin
            read_w(1'b1, i, v);
            check("R11 negative limit", v, -32768);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule